// File: doc/BRIEF.md
# Multi-Mode Interrupt Vector Generator

This block decides, for every accepted interrupt, where execution should continue. It watches one non-maskable request line and one maskable request line. It grants the non-maskable path first. It then reports the outcome as a single-cycle result. The result carries a kind code and either an opcode byte or a 16-bit address.

Maskable requests are served in one of three selectable ways:
- **Bus instruction.** The byte that the interrupting device drives during acknowledge is handed on as an opcode to execute.
- **Fixed restart.** The result is a direct jump to a fixed restart location.
- **Table lookup.** The device byte is placed under a page register to give the address of a vector-table entry that must be read.

The block does not fetch the instruction or the table entry. It only names what to fetch.

The block owns the maskable-enable flag. The flag is set and cleared by two strobes. Acceptance of any interrupt clears it, which stops nesting until software enables interrupts again. The non-maskable line is edge-sensitive. An edge that arrives while a maskable acknowledge is in progress is held and served immediately afterwards.

Top module: `intvec_gen`

## Requirements
- R1: During reset and in the first cycle after it, `ack`, `done` and `ie_flag` are 0, and `kind`, `opcode` and `target` are all zero.
- R2: A pulse on `ie_set` makes `ie_flag` 1 from the next cycle, and a pulse on `ie_clr` makes it 0. If both are high in the same cycle, `ie_clr` wins.
- R3: While `ie_flag` is 0, a high `irq_req` produces no `ack` and no `done`, for as long as it is held.
- R4: A maskable request is accepted at a clock edge where the block is idle, `irq_req` is 1, `ie_flag` is 1 and no non-maskable service is due. `ack` is then 1 for exactly the next cycle, and `ie_flag` reads 0 in that cycle.
- R5: `mode`, `i_page` and `bus_byte` are sampled in the `ack` cycle, and `done` pulses for one cycle in the cycle after `ack`. With `mode` 2'b00, or the spare code 2'b11, `kind` is 2'b00 (opcode) and `opcode` equals the sampled `bus_byte`.
- R6: With `mode` 2'b01, `done` reports `kind` 2'b01 (direct jump) and `target` 0x0038.
- R7: With `mode` 2'b10, `done` reports `kind` 2'b10 (table address) and `target` = {`i_page`, `bus_byte`}, with `i_page` in the upper eight bits.
- R8: A rising edge on `nmi_req` gives `done` in the cycle after the edge is seen at a clock edge, whatever `ie_flag` is. The result has `kind` 2'b01 and `target` 0x0066, with no `ack`. `ie_flag` is 0 afterwards.
- R9: A `nmi_req` level held high is served only once. A new service needs the line to fall and rise again.
- R10: When a non-maskable edge and a maskable request are present at the same edge, the non-maskable one is served. Because acceptance clears `ie_flag`, the maskable request then gets no `ack`.
- R11: A non-maskable edge that arrives during the `ack` cycle is remembered. Its `done` follows in the cycle directly after the maskable `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | 1 | Maskable request, level sensitive |
| ie_set | input | 1 | Strobe that sets the maskable-enable flag |
| ie_clr | input | 1 | Strobe that clears the maskable-enable flag |
| mode | input | 2 | Maskable vectoring mode: 00 bus opcode, 01 restart, 10 table, 11 as 00 |
| i_page | input | 8 | Page register, upper byte of the table address |
| bus_byte | input | 8 | Byte driven by the device during `ack` |
| ack | output | 1 | Maskable acknowledge strobe, one cycle |
| ie_flag | output | 1 | Current maskable-enable flag |
| done | output | 1 | One-cycle pulse: a new result is on `kind`/`opcode`/`target` |
| kind | output | 2 | 00 opcode to execute, 01 direct jump, 10 table address to read |
| opcode | output | 8 | Opcode byte for kind 00 |
| target | output | 16 | Jump address (kind 01) or table address (kind 10) |

## Verification
The maskable path is exercised in all four mode codes, with device bytes and page values whose halves differ. This separates the opcode, restart and table results from one another, and also catches a swapped or mis-sampled page/byte concatenation. The non-maskable path is tried as a single edge, as a long-held level and as a second edge. This tells edge detection apart from level sensing. Simultaneous requests and an edge landing inside the acknowledge cycle show whether priority, flag clearing and the pending latch work together rather than merely each alone.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  // result kinds as seen on the kind port
  typedef enum logic [1:0] {
    K_OPCODE = 2'b00,
    K_JUMP   = 2'b01,
    K_TABLE  = 2'b10
  } kind_e;

  // maskable vectoring mode codes
  localparam logic [1:0] MODE_BUS     = 2'b00;
  localparam logic [1:0] MODE_RESTART = 2'b01;
  localparam logic [1:0] MODE_TABLE   = 2'b10;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } state_e;

endpackage

// File: rtl/intvec_nmi_edge.sv
module intvec_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic take_nmi,
  output logic nmi_edge,
  output logic nmi_want
);

  logic nmi_q;
  logic pend_q;

  // rising edge relative to the level seen at the previous clock
  assign nmi_edge = nmi_req & ~nmi_q;
  // a service is due for a fresh edge or a remembered one
  assign nmi_want = nmi_edge | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_req;
      pend_q <= nmi_want & ~take_nmi;
    end
  end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import intvec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_want,
  input  logic irq_req,
  input  logic ie_set,
  input  logic ie_clr,
  output logic take_nmi,
  output logic take_irq,
  output logic in_ack,
  output logic ie_flag
);

  state_e state_q;
  logic   ie_q;
  logic   idle;
  logic   take_any;

  assign idle     = (state_q == ST_IDLE);
  // non-maskable first; maskable only when enabled and nothing else is due
  assign take_nmi = idle & nmi_want;
  assign take_irq = idle & ~nmi_want & irq_req & ie_q;
  assign take_any = take_nmi | take_irq;
  assign in_ack   = (state_q == ST_ACK);
  assign ie_flag  = ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ie_q    <= 1'b0;
    end else begin
      state_q <= take_irq ? ST_ACK : ST_IDLE;
      if (take_any || ie_clr) ie_q <= 1'b0;
      else if (ie_set)        ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/intvec_out.sv
module intvec_out
  import intvec_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          PAGE_W  = 8,
  parameter int unsigned RST_VEC = 32'h0038,
  parameter int unsigned NMI_VEC = 32'h0066
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_nmi,
  input  logic                     in_ack,
  input  logic [1:0]               mode,
  input  logic [PAGE_W-1:0]        i_page,
  input  logic [DATA_W-1:0]        bus_byte,
  output logic                     done,
  output logic [1:0]               kind,
  output logic [DATA_W-1:0]        opcode,
  output logic [PAGE_W+DATA_W-1:0] target
);

  localparam int ADDR_W = PAGE_W + DATA_W;

  // kind of result for a maskable request in a given mode
  function automatic logic [1:0] mode_kind(input logic [1:0] m);
    case (m)
      MODE_RESTART: mode_kind = K_JUMP;
      MODE_TABLE:   mode_kind = K_TABLE;
      default:      mode_kind = K_OPCODE;
    endcase
  endfunction

  // address for a maskable request; zero when the result is an opcode
  function automatic logic [ADDR_W-1:0] mode_target(input logic [1:0]        m,
                                                    input logic [PAGE_W-1:0] pg,
                                                    input logic [DATA_W-1:0] b);
    case (m)
      MODE_RESTART: mode_target = ADDR_W'(RST_VEC);
      MODE_TABLE:   mode_target = {pg, b};
      default:      mode_target = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      kind   <= K_OPCODE;
      opcode <= '0;
      target <= '0;
    end else begin
      done <= take_nmi | in_ack;
      if (take_nmi) begin
        kind   <= K_JUMP;
        opcode <= '0;
        target <= ADDR_W'(NMI_VEC);
      end else if (in_ack) begin
        kind   <= mode_kind(mode);
        opcode <= (mode_kind(mode) == K_OPCODE) ? bus_byte : '0;
        target <= mode_target(mode, i_page, bus_byte);
      end
    end
  end

endmodule

// File: rtl/intvec_gen.sv
module intvec_gen #(
  parameter int          DATA_W  = 8,
  parameter int          PAGE_W  = 8,
  parameter int unsigned RST_VEC = 32'h0038,
  parameter int unsigned NMI_VEC = 32'h0066
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     nmi_req,
  input  logic                     irq_req,
  input  logic                     ie_set,
  input  logic                     ie_clr,
  input  logic [1:0]               mode,
  input  logic [PAGE_W-1:0]        i_page,
  input  logic [DATA_W-1:0]        bus_byte,
  output logic                     ack,
  output logic                     ie_flag,
  output logic                     done,
  output logic [1:0]               kind,
  output logic [DATA_W-1:0]        opcode,
  output logic [PAGE_W+DATA_W-1:0] target
);

  // internal events, named for the checker
  logic nmi_edge;
  logic nmi_want;
  logic take_nmi;
  logic take_irq;
  logic in_ack;

  intvec_nmi_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_req  (nmi_req),
    .take_nmi (take_nmi),
    .nmi_edge (nmi_edge),
    .nmi_want (nmi_want)
  );

  intvec_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_want (nmi_want),
    .irq_req  (irq_req),
    .ie_set   (ie_set),
    .ie_clr   (ie_clr),
    .take_nmi (take_nmi),
    .take_irq (take_irq),
    .in_ack   (in_ack),
    .ie_flag  (ie_flag)
  );

  intvec_out #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .RST_VEC (RST_VEC),
    .NMI_VEC (NMI_VEC)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_nmi (take_nmi),
    .in_ack   (in_ack),
    .mode     (mode),
    .i_page   (i_page),
    .bus_byte (bus_byte),
    .done     (done),
    .kind     (kind),
    .opcode   (opcode),
    .target   (target)
  );

  assign ack = in_ack;

endmodule

// File: rtl/intvec_chk.sv
module intvec_chk #(
  parameter int          DATA_W  = 8,
  parameter int          PAGE_W  = 8,
  parameter int unsigned NMI_VEC = 32'h0066
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ack,
  input logic                     ie_flag,
  input logic                     done,
  input logic [1:0]               kind,
  input logic [1:0]               mode,
  input logic [PAGE_W-1:0]        i_page,
  input logic [DATA_W-1:0]        bus_byte,
  input logic [PAGE_W+DATA_W-1:0] target,
  input logic                     take_nmi,
  input logic                     take_irq
);

  // R3
  ign_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_flag |=> !ack);

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R4
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ie_flag);

  // R4
  take_gives_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> ack);

  // R7
  table_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && mode == 2'b10) |=> (done && kind == 2'b10 &&
      target == {$past(i_page), $past(bus_byte)}));

  // R8
  nmi_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (done && !ack && !ie_flag && kind == 2'b01 &&
      target == (PAGE_W+DATA_W)'(NMI_VEC)));

  // R10
  nmi_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_nmi && take_irq));

  // R5
  done_apart_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ack));

endmodule

bind intvec_gen intvec_chk #(
  .DATA_W  (DATA_W),
  .PAGE_W  (PAGE_W),
  .NMI_VEC (NMI_VEC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .ie_flag  (ie_flag),
  .done     (done),
  .kind     (kind),
  .mode     (mode),
  .i_page   (i_page),
  .bus_byte (bus_byte),
  .target   (target),
  .take_nmi (take_nmi),
  .take_irq (take_irq)
);

// File: tb/intvec_gen_bench.sv
module intvec_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0;
  logic        irq_req = 1'b0;
  logic        ie_set = 1'b0;
  logic        ie_clr = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  i_page = 8'h00;
  logic [7:0]  bus_byte = 8'h00;
  logic        ack;
  logic        ie_flag;
  logic        done;
  logic [1:0]  kind;
  logic [7:0]  opcode;
  logic [15:0] target;

  int tests  = 0;
  int failed = 0;

  always #2 clk = ~clk;

  intvec_gen u_intvec_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_req  (nmi_req),
    .irq_req  (irq_req),
    .ie_set   (ie_set),
    .ie_clr   (ie_clr),
    .mode     (mode),
    .i_page   (i_page),
    .bus_byte (bus_byte),
    .ack      (ack),
    .ie_flag  (ie_flag),
    .done     (done),
    .kind     (kind),
    .opcode   (opcode),
    .target   (target)
  );

  // advance past one rising edge and settle away from it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic enable_ie();
    ie_set = 1'b1;
    step();
    ie_set = 1'b0;
    chk("R2", "ie_flag after set", ie_flag, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    step();
    chk("R1", "ack in reset", ack, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "ie in reset", ie_flag, 0);
    rst_n = 1'b1;
    step();
    chk("R1", "kind after reset", kind, 0);
    chk("R1", "target after reset", target, 0);
    chk("R1", "opcode after reset", opcode, 0);
  endtask

  task automatic t_ie_ctrl();
    enable_ie();
    ie_clr = 1'b1;
    step();
    ie_clr = 1'b0;
    chk("R2", "ie after clr", ie_flag, 0);
    ie_set = 1'b1;
    ie_clr = 1'b1;
    step();
    ie_set = 1'b0;
    ie_clr = 1'b0;
    chk("R2", "clr wins over set", ie_flag, 0);
  endtask

  task automatic t_masked();
    int seen = 0;
    irq_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (ack || done) seen++;
    end
    irq_req = 1'b0;
    chk("R3", "ack/done while disabled", seen, 0);
  endtask

  // one maskable service in mode m; checks ack timing and the result
  task automatic t_irq(input logic [1:0] m, input logic [7:0] pg,
                       input logic [7:0] b);
    enable_ie();
    mode     = m;
    i_page   = pg;
    bus_byte = b;
    irq_req  = 1'b1;
    step();
    irq_req = 1'b0;
    chk("R4", "ack after accept", ack, 1);
    chk("R4", "ie cleared in ack", ie_flag, 0);
    chk("R4", "no done during ack", done, 0);
    step();
    chk("R4", "ack one cycle", ack, 0);
    chk("R5", "done after ack", done, 1);
    case (m)
      2'b01: begin
        chk("R6", "restart kind", kind, 1);
        chk("R6", "restart target", target, 16'h0038);
      end
      2'b10: begin
        chk("R7", "table kind", kind, 2);
        chk("R7", "table target", target, {pg, b});
      end
      default: begin
        chk("R5", "opcode kind", kind, 0);
        chk("R5", "opcode byte", opcode, b);
      end
    endcase
    step();
    chk("R5", "done one cycle", done, 0);
  endtask

  task automatic t_nmi();
    int extra = 0;
    nmi_req = 1'b1;
    step();
    chk("R8", "nmi done", done, 1);
    chk("R8", "nmi kind", kind, 1);
    chk("R8", "nmi target", target, 16'h0066);
    chk("R8", "nmi no ack", ack, 0);
    chk("R8", "nmi ie", ie_flag, 0);
    for (int i = 0; i < 8; i++) begin
      step();
      if (done) extra++;
    end
    chk("R9", "held level extra services", extra, 0);
    nmi_req = 1'b0;
    step();
    nmi_req = 1'b1;
    step();
    chk("R9", "second edge served", done, 1);
    nmi_req = 1'b0;
    step();
  endtask

  task automatic t_priority();
    enable_ie();
    mode    = 2'b01;
    nmi_req = 1'b1;
    irq_req = 1'b1;
    step();
    chk("R10", "nmi first done", done, 1);
    chk("R10", "nmi first target", target, 16'h0066);
    chk("R10", "no ack with nmi", ack, 0);
    step();
    chk("R10", "irq not acked after", ack, 0);
    nmi_req = 1'b0;
    irq_req = 1'b0;
    step();
  endtask

  task automatic t_nmi_in_ack();
    enable_ie();
    mode     = 2'b10;
    i_page   = 8'h5A;
    bus_byte = 8'hC3;
    irq_req  = 1'b1;
    step();
    irq_req = 1'b0;
    chk("R11", "ack present", ack, 1);
    nmi_req = 1'b1;
    step();
    chk("R11", "irq done first", done, 1);
    chk("R11", "irq result table", target, 16'h5AC3);
    step();
    chk("R11", "pending nmi done", done, 1);
    chk("R11", "pending nmi target", target, 16'h0066);
    nmi_req = 1'b0;
    step();
    chk("R11", "done ends", done, 0);
  endtask

  initial begin
    #100000;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    t_reset();
    t_ie_ctrl();
    t_masked();
    t_irq(2'b00, 8'h12, 8'hA7);
    t_irq(2'b01, 8'h12, 8'hA7);
    t_irq(2'b10, 8'h3C, 8'h81);
    t_irq(2'b10, 8'hF0, 8'h0F);
    t_irq(2'b11, 8'h44, 8'h5E);
    t_nmi();
    t_priority();
    t_nmi_in_ack();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule